// File: doc/BRIEF.md
# Pixel Format Decoder and Colour-Space Matrix

This block sits at the input of a composite video encoder. On each rising edge of the pixel clock it captures three 8-bit data buses together with a 3-bit format code and a blanking flag. The format code says whether the buses carry RGB or YUV, and it also sets the dither enables that later stages use. RGB pixels go through a fixed-point luma and colour-difference matrix. YUV pixels take a bypass path of the same length, with their channels routed from the buses on which they arrive.

Y leaves the block unsigned. U and V leave it in two's complement. The latency from input to output is three pixel clocks on both paths, so stages further down never need to know which format was in use. While the blanking flag is set, the captured data is replaced by black with zero colour difference.

Top module: `pixel_csc`

## Requirements
- R1: While rst_n is low, y_out, u_out, v_out, rgb_dith_en and luma_dith_en are all 0.
- R2: For RGB codes (000, 001, 010, 011), y_out = (297R + 582G + 113B + 512) >> 10, u_out = floor((-138R - 271G + 409B + 512) / 1024) and v_out = floor((430R - 360G - 70B + 512) / 1024). R, G and B are unsigned 0..255 on red_in, grn_in and blu_in.
- R3: For any grey RGB input (R = G = B), u_out and v_out are 0. Full white (255,255,255) gives y_out = 247, and black gives y_out = 0.
- R4: For YUV codes (100 and 101), y_out is taken from red_in, u_out from blu_in and v_out from grn_in. U and V are read as 8-bit two's complement.
- R5: In YUV mode, Y is clamped to at most 247, U to the range -102..102 and V to the range -107..107. On the matrix path, outputs never leave these bounds either.
- R6: A pixel presented before rising edge n appears on every output after rising edge n+2. This holds on both the matrix path and the YUV path.
- R7: When blank_in is 1 with a pixel, that pixel comes out as y_out = 0, u_out = 0 and v_out = 0, whatever the data buses carry. The latency is the same as in R6.
- R8: The dither enables decode as follows. Code 000 gives rgb=1 luma=0. Code 001 gives rgb=1 luma=1. Code 010 gives rgb=0 luma=1. Code 011 gives rgb=0 luma=0. Code 100 gives rgb=0 luma=1. Code 101 gives rgb=0 luma=0.
- R9: Codes 110 and 111 use the RGB matrix of R2 with both dither enables 0.
- R10: The format code is captured with each pixel. Changing it between two consecutive pixels affects only the pixels that carry the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| red_in | input | 8 | Red bus; carries Y in YUV mode |
| grn_in | input | 8 | Green bus; carries V in YUV mode |
| blu_in | input | 8 | Blue bus; carries U in YUV mode |
| fmt_code | input | 3 | Format and dither select code |
| blank_in | input | 1 | Composite blanking flag for this pixel |
| y_out | output | 8 | Luma, unsigned |
| u_out | output | 8 | Blue colour difference, two's complement |
| v_out | output | 8 | Red colour difference, two's complement |
| rgb_dith_en | output | 1 | Enable for input dither |
| luma_dith_en | output | 1 | Enable for luma dither |

## Verification
The bench feeds grey levels, primaries and their complements. A wrong or unbalanced coefficient would show up as a tinted grey, or as a white that misses 247. YUV tests send bus values beyond the legal limits, including -128 and 127. This catches a swapped bus route, a missing clamp, or an unsigned reading of U and V. A back-to-back stream mixes RGB, YUV, reserved and blanked pixels. A bypass path one stage short or long would put pixels out of step with their neighbours. A format code that is not pipelined with its pixel would apply the wrong decode to the neighbouring pixels.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W  = 8;
  localparam int FRAC_W = 10;
  localparam int ACC_W  = 20;

  localparam int Y_MAX = 247;
  localparam int U_LIM = 102;
  localparam int V_LIM = 107;

  // luma weights, scaled so full white lands on Y_MAX
  localparam int KY_R = 297;
  localparam int KY_G = 582;
  localparam int KY_B = 113;
  // colour-difference weights; each row sums to zero
  localparam int KU_R = -138;
  localparam int KU_G = -271;
  localparam int KU_B = 409;
  localparam int KV_R = 430;
  localparam int KV_G = -360;
  localparam int KV_B = -70;

  typedef struct packed {
    logic is_yuv;
    logic rgb_dith;
    logic luma_dith;
  } fmt_t;
endpackage

// File: rtl/csc_fmt_decode.sv
module csc_fmt_decode
  import csc_pkg::*;
(
  input  logic [2:0] code,
  output fmt_t       fmt
);
  always_comb begin
    fmt = '0;
    unique case (code)
      3'b100: begin fmt.is_yuv = 1'b1; fmt.luma_dith = 1'b1; end
      3'b101: begin fmt.is_yuv = 1'b1; end
      3'b110,
      3'b111: fmt = '0;
      default: begin
        fmt.rgb_dith  = ~code[1];
        fmt.luma_dith = code[1] ^ code[0];
      end
    endcase
  end
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
  import csc_pkg::*;
#(
  parameter int PW = PIX_W,
  parameter int AW = ACC_W
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-1:0]        r_in,
  input  logic [PW-1:0]        g_in,
  input  logic [PW-1:0]        b_in,
  output logic signed [AW-1:0] y_acc,
  output logic signed [AW-1:0] u_acc,
  output logic signed [AW-1:0] v_acc
);
  localparam int PAD = AW - PW;

  logic signed [AW-1:0] r_s, g_s, b_s;
  logic signed [AW-1:0] y_nxt, u_nxt, v_nxt;

  assign r_s = $signed({{PAD{1'b0}}, r_in});
  assign g_s = $signed({{PAD{1'b0}}, g_in});
  assign b_s = $signed({{PAD{1'b0}}, b_in});

  always_comb begin
    y_nxt = r_s * $signed(AW'(KY_R)) + g_s * $signed(AW'(KY_G)) + b_s * $signed(AW'(KY_B));
    u_nxt = r_s * $signed(AW'(KU_R)) + g_s * $signed(AW'(KU_G)) + b_s * $signed(AW'(KU_B));
    v_nxt = r_s * $signed(AW'(KV_R)) + g_s * $signed(AW'(KV_G)) + b_s * $signed(AW'(KV_B));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_acc <= '0;
      u_acc <= '0;
      v_acc <= '0;
    end else begin
      y_acc <= y_nxt;
      u_acc <= u_nxt;
      v_acc <= v_nxt;
    end
  end

  // R3: grey in, no colour difference out
  a_r3_grey_neutral: assert property (@(posedge clk) disable iff (!rst_n)
    (r_in == g_in && g_in == b_in) |=> (u_acc == 0 && v_acc == 0));
endmodule

// File: rtl/csc_out_stage.sv
module csc_out_stage
  import csc_pkg::*;
#(
  parameter int PW = PIX_W,
  parameter int AW = ACC_W,
  parameter int FW = FRAC_W
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [AW-1:0] y_acc,
  input  logic signed [AW-1:0] u_acc,
  input  logic signed [AW-1:0] v_acc,
  input  logic [PW-1:0]        raw_y,
  input  logic [PW-1:0]        raw_u,
  input  logic [PW-1:0]        raw_v,
  input  fmt_t                 fmt,
  input  logic                 blank,
  output logic [PW-1:0]        y_out,
  output logic signed [PW-1:0] u_out,
  output logic signed [PW-1:0] v_out,
  output logic                 rgb_dith_en,
  output logic                 luma_dith_en
);
  localparam logic signed [AW-1:0] RND = AW'(1 << (FW - 1));

  logic signed [AW-1:0] y_r, u_r, v_r;
  logic [PW-1:0]        y_nxt;
  logic signed [PW-1:0] u_nxt, v_nxt, u_byp, v_byp;

  always_comb begin
    y_r = (y_acc + RND) >>> FW;
    u_r = (u_acc + RND) >>> FW;
    v_r = (v_acc + RND) >>> FW;

    u_byp = $signed(raw_u);
    if (u_byp > $signed(PW'(U_LIM)))       u_byp = PW'(U_LIM);
    else if (u_byp < $signed(PW'(-U_LIM))) u_byp = PW'(-U_LIM);
    v_byp = $signed(raw_v);
    if (v_byp > $signed(PW'(V_LIM)))       v_byp = PW'(V_LIM);
    else if (v_byp < $signed(PW'(-V_LIM))) v_byp = PW'(-V_LIM);

    if (fmt.is_yuv) begin
      y_nxt = (raw_y > PW'(Y_MAX)) ? PW'(Y_MAX) : raw_y;
      u_nxt = u_byp;
      v_nxt = v_byp;
    end else begin
      y_nxt = y_r[PW-1:0];
      u_nxt = u_r[PW-1:0];
      v_nxt = v_r[PW-1:0];
    end

    if (blank) begin
      y_nxt = '0;
      u_nxt = '0;
      v_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out        <= '0;
      u_out        <= '0;
      v_out        <= '0;
      rgb_dith_en  <= 1'b0;
      luma_dith_en <= 1'b0;
    end else begin
      y_out        <= y_nxt;
      u_out        <= u_nxt;
      v_out        <= v_nxt;
      rgb_dith_en  <= fmt.rgb_dith;
      luma_dith_en <= fmt.luma_dith;
    end
  end

  // R5: output ranges on both paths
  a_r5_y_limit: assert property (@(posedge clk) disable iff (!rst_n)
    int'(y_out) <= Y_MAX);
  a_r5_u_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(u_out) <= U_LIM) && (int'(u_out) >= -U_LIM));
  a_r5_v_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(v_out) <= V_LIM) && (int'(v_out) >= -V_LIM));
endmodule

// File: rtl/pixel_csc.sv
module pixel_csc
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        red_in,
  input  logic [7:0]        grn_in,
  input  logic [7:0]        blu_in,
  input  logic [2:0]        fmt_code,
  input  logic              blank_in,
  output logic [7:0]        y_out,
  output logic signed [7:0] u_out,
  output logic signed [7:0] v_out,
  output logic              rgb_dith_en,
  output logic              luma_dith_en
);
  fmt_t fmt_dec;
  logic [PIX_W-1:0] s1_r, s1_g, s1_b, s2_r, s2_g, s2_b;
  fmt_t s1_fmt, s2_fmt;
  logic s1_blank, s2_blank;
  logic signed [ACC_W-1:0] y_acc, u_acc, v_acc;

  csc_fmt_decode u_dec (.code(fmt_code), .fmt(fmt_dec));

  // stage 1: capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_r <= '0; s1_g <= '0; s1_b <= '0;
      s1_fmt <= '0; s1_blank <= 1'b0;
    end else begin
      s1_r <= red_in; s1_g <= grn_in; s1_b <= blu_in;
      s1_fmt <= fmt_dec; s1_blank <= blank_in;
    end
  end

  // stage 2: matrix products, bypass data held alongside
  csc_matrix #(.PW(PIX_W), .AW(ACC_W)) u_mtx (
    .clk(clk), .rst_n(rst_n),
    .r_in(s1_r), .g_in(s1_g), .b_in(s1_b),
    .y_acc(y_acc), .u_acc(u_acc), .v_acc(v_acc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_r <= '0; s2_g <= '0; s2_b <= '0;
      s2_fmt <= '0; s2_blank <= 1'b0;
    end else begin
      s2_r <= s1_r; s2_g <= s1_g; s2_b <= s1_b;
      s2_fmt <= s1_fmt; s2_blank <= s1_blank;
    end
  end

  // stage 3: round, select path, clamp, blank
  csc_out_stage #(.PW(PIX_W), .AW(ACC_W), .FW(FRAC_W)) u_out_stg (
    .clk(clk), .rst_n(rst_n),
    .y_acc(y_acc), .u_acc(u_acc), .v_acc(v_acc),
    .raw_y(s2_r), .raw_u(s2_b), .raw_v(s2_g),
    .fmt(s2_fmt), .blank(s2_blank),
    .y_out(y_out), .u_out(u_out), .v_out(v_out),
    .rgb_dith_en(rgb_dith_en), .luma_dith_en(luma_dith_en));

  // R7: blanked pixel leaves as black, three edges later
  a_r7_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    blank_in |-> ##3 (y_out == 0 && u_out == 0 && v_out == 0));
  // R9: reserved codes switch both dithers off
  a_r9_reserved_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_code[2] && fmt_code[1]) |-> ##3 (!rgb_dith_en && !luma_dith_en));
  // R8: YUV codes never enable input dither
  a_r8_yuv_no_rgb_dith: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_code[2] && !fmt_code[1]) |-> ##3 !rgb_dith_en);
endmodule

// File: tb/pixel_csc_bench.sv
`timescale 1ns/1ps
module pixel_csc_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] red_in, grn_in, blu_in;
  logic [2:0] fmt_code;
  logic blank_in;
  logic [7:0] y_out;
  logic signed [7:0] u_out, v_out;
  logic rgb_dith_en, luma_dith_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pixel_csc u_pixel_csc (
    .clk(clk), .rst_n(rst_n), .red_in(red_in), .grn_in(grn_in), .blu_in(blu_in),
    .fmt_code(fmt_code), .blank_in(blank_in), .y_out(y_out), .u_out(u_out),
    .v_out(v_out), .rgb_dith_en(rgb_dith_en), .luma_dith_en(luma_dith_en));

  function automatic int sx8(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int clip(input int v, input int lo, input int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  // reference model built from R2, R4, R5, R7, R8, R9
  task automatic model(input int r, input int g, input int b, input logic [2:0] c,
                       input logic bl, output int ey, output int eu, output int ev,
                       output logic erd, output logic eld);
    if (c == 3'b100 || c == 3'b101) begin
      ey = clip(r, 0, 247); eu = clip(sx8(b), -102, 102); ev = clip(sx8(g), -107, 107);
      erd = 1'b0; eld = (c == 3'b100);
    end else begin
      ey = (297*r + 582*g + 113*b + 512) >>> 10;
      eu = (-138*r - 271*g + 409*b + 512) >>> 10;
      ev = (430*r - 360*g - 70*b + 512) >>> 10;
      if (c[2]) begin erd = 1'b0; eld = 1'b0; end
      else begin erd = ~c[1]; eld = c[1] ^ c[0]; end
    end
    if (bl) begin ey = 0; eu = 0; ev = 0; end
  endtask

  task automatic check_out(input string req, input int ey, input int eu, input int ev,
                           input logic erd, input logic eld);
    checks++;
    if (int'(y_out) != ey || int'(u_out) != eu || int'(v_out) != ev ||
        rgb_dith_en != erd || luma_dith_en != eld) begin
      errors++;
      $display("FAIL %s: got y=%0d u=%0d v=%0d rd=%0b ld=%0b, expected y=%0d u=%0d v=%0d rd=%0b ld=%0b",
               req, y_out, u_out, v_out, rgb_dith_en, luma_dith_en, ey, eu, ev, erd, eld);
    end
  endtask

  task automatic drive(input int r, input int g, input int b, input logic [2:0] c, input logic bl);
    red_in = 8'(r); grn_in = 8'(g); blu_in = 8'(b); fmt_code = c; blank_in = bl;
  endtask

  // drive at a falling edge, sample three falling edges later (R6)
  task automatic pix(input string req, input int r, input int g, input int b,
                     input logic [2:0] c, input logic bl);
    int ey, eu, ev; logic erd, eld;
    @(negedge clk);
    drive(r, g, b, c, bl);
    repeat (3) @(negedge clk);
    model(r & 255, g & 255, b & 255, c, bl, ey, eu, ev, erd, eld);
    check_out(req, ey, eu, ev, erd, eld);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive(200, 100, 50, 3'b001, 1'b0);
    repeat (4) @(negedge clk);
    check_out("R1 reset", 0, 0, 0, 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_matrix;
    pix("R2 red", 255, 0, 0, 3'b001, 1'b0);
    pix("R2 green", 0, 255, 0, 3'b001, 1'b0);
    pix("R2 blue", 0, 0, 255, 3'b001, 1'b0);
    pix("R2 yellow", 255, 255, 0, 3'b000, 1'b0);
    pix("R2 cyan", 0, 255, 255, 3'b010, 1'b0);
    pix("R2 magenta", 255, 0, 255, 3'b011, 1'b0);
    pix("R2 mixed", 17, 201, 96, 3'b001, 1'b0);
  endtask

  task automatic t_grey;
    pix("R3 white", 255, 255, 255, 3'b001, 1'b0);
    pix("R3 black", 0, 0, 0, 3'b001, 1'b0);
    pix("R3 grey", 128, 128, 128, 3'b001, 1'b0);
    pix("R3 grey low", 3, 3, 3, 3'b000, 1'b0);
  endtask

  task automatic t_yuv;
    pix("R4 yuv route", 120, 8'hF6, 40, 3'b100, 1'b0);
    pix("R4 yuv negatives", 16, 90, 8'hA0, 3'b101, 1'b0);
  endtask

  task automatic t_clamp;
    pix("R5 yuv over", 255, 127, 127, 3'b100, 1'b0);
    pix("R5 yuv under", 248, 8'h80, 8'h80, 3'b101, 1'b0);
    pix("R5 yuv edge", 247, 8'h95, 8'h9A, 3'b100, 1'b0);
  endtask

  task automatic t_blank;
    pix("R7 blank rgb", 255, 255, 255, 3'b001, 1'b1);
    pix("R7 blank yuv", 200, 100, 100, 3'b100, 1'b1);
  endtask

  task automatic t_decode;
    for (int c = 0; c < 8; c++) begin
      string s;
      s = (c >= 6) ? "R9 reserved code" : "R8 dither decode";
      pix(s, 60, 90, 30, 3'(c), 1'b0);
    end
  endtask

  // back-to-back pixels with mixed codes: R6 and R10
  task automatic t_stream;
    int sr[6] = '{255, 200, 10, 0, 77, 255};
    int sg[6] = '{0, 8'h85, 20, 255, 77, 255};
    int sb[6] = '{0, 60, 30, 0, 77, 8'h90};
    logic [2:0] sc[6] = '{3'b001, 3'b100, 3'b111, 3'b010, 3'b000, 3'b101};
    logic sbl[6] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    int ey, eu, ev; logic erd, eld;
    for (int t = 0; t < 9; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        model(sr[t-3], sg[t-3], sb[t-3], sc[t-3], sbl[t-3], ey, eu, ev, erd, eld);
        check_out("R6 R10 stream", ey, eu, ev, erd, eld);
      end
      if (t < 6) drive(sr[t], sg[t], sb[t], sc[t], sbl[t]);
      else drive(0, 0, 0, 3'b001, 1'b0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_matrix();
    t_grey();
    t_yuv();
    t_clamp();
    t_blank();
    t_decode();
    t_stream();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule